// File: doc/BRIEF.md
# Paged ROM Window Address Decoder

This block sits on the 16-bit address bus of an 8-bit CPU and turns each bus cycle into active-low chip selects. The lower part of the address space, 0x0000 to 0x9fff, is a window onto a larger banked ROM image. A 4-bit page number, loaded by a CPU write to a page register, chooses which ROM devices appear in that window. For every banked read the block also produces the byte offset into one flat image that holds all five banked ROM devices back to back.

Above the window, work RAM, palette RAM and the fixed ROM are decoded from the address alone, whatever the page. Only pages whose two low bits are zero map ROM into the window. Page bit 3 has no effect, so each such page has an alias. When a read in the window finds no device, the block raises a fill enable so that the data bus returns 0xFF.

Top module: `paged_rom_decoder`

## Requirements
- R1: A write cycle (`cpu_wr`=1) to address 0xC900 loads `cpu_wdata[3:0]` into the page register on the rising clock edge. Bits 7:4 are ignored, and reads of that address or writes elsewhere leave the page unchanged. After reset the page is 0.
- R2: When page bits 2:0 are 000, reads at 0x0000-0x3fff assert R1 (`rom_cs_n[0]`), reads at 0x4000-0x7fff assert R3 (`rom_cs_n[2]`), and reads at 0x8000-0x9fff assert R5 (`rom_cs_n[4]`).
- R3: When page bits 2:0 are 100, reads at 0x0000-0x3fff assert R2 (`rom_cs_n[1]`), reads at 0x4000-0x7fff assert R4 (`rom_cs_n[3]`), and reads at 0x8000-0x9fff assert no ROM select.
- R4: Page bit 3 has no effect: pages 0x8 and 0xC decode exactly like pages 0x0 and 0x4.
- R5: `bank_addr` is the device base plus the offset inside its window slot. The bases are R1 0x00000, R2 0x04000, R3 0x08000, R4 0x0C000 and R5 0x10000. The offset is A13:A0, or A12:A0 for the R5 slot. `bank_addr` is 0 whenever no ROM select is active.
- R6: Write cycles inside the window assert no ROM select.
- R7: Pages with bits 1:0 nonzero assert no ROM select anywhere in the window.
- R8: `fill_oe` is 1 exactly on read cycles inside the window that assert no ROM select. The data bus then reads 0xFF.
- R9: Work RAM (`wram_cs_n`) is selected at 0xa000-0xbfff, palette RAM (`pal_cs_n`) at 0xc000-0xc7ff, and fixed ROM (`fixrom_cs_n`) at 0xe000-0xffff. These selects respond on read or write cycles, independent of the page. No select is active in 0xc800-0xdfff.
- R10: At most one chip select is low at any time, and all selects are high when neither `cpu_rd` nor `cpu_wr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read cycle strobe |
| cpu_wr | input | 1 | Write cycle strobe |
| rom_cs_n | output | 5 | Banked ROM selects, bit 0 = R1 ... bit 4 = R5, active low |
| wram_cs_n | output | 1 | Work RAM select, active low |
| pal_cs_n | output | 1 | Palette RAM select, active low |
| fixrom_cs_n | output | 1 | Fixed ROM select, active low |
| bank_addr | output | 17 | Offset into the flat banked ROM image |
| fill_oe | output | 1 | Drive 0xFF onto the data bus for an empty window read |

## Verification
The page register is the block's only state. A wrong page value shows at the ports on the first window read after the faulty write: the wrong ROM select goes low, or none does, and the base in `bank_addr` shifts by a multiple of 0x4000. Because the decode is combinational, every select or offset error appears in the same cycle as the address that causes it. Each page value is therefore checked by a read in each of the three window slots right after the page write, and the address boundaries are checked at both their first and last bytes.

// File: rtl/prw_pkg.sv
package prw_pkg;

    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 4;
    localparam int NUM_ROM = 5;
    localparam int IMG_W   = 17;

    // Bank identifiers; the numeric value is the rom_cs_n bit index.
    typedef enum logic [2:0] {
        BANK_LO0  = 3'd0,   // R1
        BANK_LO1  = 3'd1,   // R2
        BANK_MID0 = 3'd2,   // R3
        BANK_MID1 = 3'd3,   // R4
        BANK_HI   = 3'd4,   // R5
        BANK_NONE = 3'd7
    } bank_id_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } page_state_t;

    typedef struct packed {
        bank_id_e         id;
        logic [IMG_W-1:0] img_addr;
        logic             fill;
    } win_dec_t;

    function automatic logic [IMG_W-1:0] bank_base(input bank_id_e id);
        case (id)
            BANK_LO0:  bank_base = IMG_W'('h00000);
            BANK_LO1:  bank_base = IMG_W'('h04000);
            BANK_MID0: bank_base = IMG_W'('h08000);
            BANK_MID1: bank_base = IMG_W'('h0c000);
            BANK_HI:   bank_base = IMG_W'('h10000);
            default:   bank_base = '0;
        endcase
    endfunction

endpackage

// File: rtl/prw_page_reg.sv
module prw_page_reg
    import prw_pkg::*;
#(
    parameter int                AW        = ADDR_W,
    parameter int                PW        = PAGE_W,
    parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hc900
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [PW-1:0] wdata_lo,
    input  logic          cpu_wr,
    output logic [PW-1:0] page
);

    page_state_t st_d, st_q;
    logic        load;

    always_comb begin
        st_d = st_q;
        load = cpu_wr && (cpu_addr == PAGE_ADDR);
        if (load) begin
            st_d.page = wdata_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == PAGE_ADDR) |=> (page == $past(wdata_lo))); // R1
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == PAGE_ADDR) |=> $stable(page)); // R1

endmodule

// File: rtl/prw_window_decode.sv
module prw_window_decode
    import prw_pkg::*;
#(
    parameter int                AW       = ADDR_W,
    parameter int                PW       = PAGE_W,
    parameter int                NROM     = NUM_ROM,
    parameter int                BAW      = IMG_W,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'h9fff
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [PW-1:0]   page,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    output logic [NROM-1:0] rom_cs_n,
    output logic [BAW-1:0]  bank_addr,
    output logic            fill_oe
);

    localparam int SLOT_BITS = AW - 2;       // 16 KiB slots
    localparam int HI_BITS   = SLOT_BITS - 1; // top slot is 8 KiB

    win_dec_t         dec;
    logic             in_win;
    logic             rd_cyc;
    logic [1:0]       slot;
    logic [BAW-1:0]   offset;

    always_comb begin
        in_win = (cpu_addr <= WIN_LAST);
        rd_cyc = cpu_rd && !cpu_wr;
        slot   = cpu_addr[AW-1:AW-2];
        dec    = '{id: BANK_NONE, img_addr: '0, fill: 1'b0};

        if (in_win && rd_cyc && (page[1:0] == 2'b00)) begin
            case (slot)
                2'd0:    dec.id = page[2] ? BANK_LO1  : BANK_LO0;
                2'd1:    dec.id = page[2] ? BANK_MID1 : BANK_MID0;
                default: dec.id = page[2] ? BANK_NONE : BANK_HI;
            endcase
        end

        if (slot[1]) begin
            offset = BAW'(cpu_addr[HI_BITS-1:0]);
        end else begin
            offset = BAW'(cpu_addr[SLOT_BITS-1:0]);
        end

        if (dec.id != BANK_NONE) begin
            dec.img_addr = bank_base(dec.id) + offset;
        end
        dec.fill = in_win && rd_cyc && (dec.id == BANK_NONE);
    end

    for (genvar i = 0; i < NROM; i++) begin : g_rom_cs
        assign rom_cs_n[i] = (dec.id != bank_id_e'(i));
    end

    assign bank_addr = dec.img_addr;
    assign fill_oe   = dec.fill;

    AST_NO_WR_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (&rom_cs_n)); // R6
    AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_oe |-> ((&rom_cs_n) && cpu_rd)); // R8
    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (&rom_cs_n) |-> (bank_addr == '0)); // R5
    AST_ODD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (page[1:0] != 2'b00) |-> (&rom_cs_n)); // R7

endmodule

// File: rtl/prw_fixed_decode.sv
module prw_fixed_decode
    import prw_pkg::*;
#(
    parameter int                AW     = ADDR_W,
    parameter logic [ADDR_W-1:0] RAM_LO = 16'ha000,
    parameter logic [ADDR_W-1:0] RAM_HI = 16'hbfff,
    parameter logic [ADDR_W-1:0] PAL_LO = 16'hc000,
    parameter logic [ADDR_W-1:0] PAL_HI = 16'hc7ff,
    parameter logic [ADDR_W-1:0] FIX_LO = 16'he000,
    parameter logic [ADDR_W-1:0] FIX_HI = 16'hffff
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic          wram_cs_n,
    output logic          pal_cs_n,
    output logic          fixrom_cs_n
);

    localparam int NREG = 3;

    logic [NREG-1:0] hit;
    logic            active;

    function automatic logic [2*ADDR_W-1:0] region(input int k);
        case (k)
            0:       region = {RAM_LO, RAM_HI};
            1:       region = {PAL_LO, PAL_HI};
            default: region = {FIX_LO, FIX_HI};
        endcase
    endfunction

    assign active = cpu_rd || cpu_wr;

    for (genvar k = 0; k < NREG; k++) begin : g_region
        localparam logic [2*ADDR_W-1:0] BOUNDS = region(k);
        localparam logic [AW-1:0]       LO     = BOUNDS[2*ADDR_W-1:ADDR_W];
        localparam logic [AW-1:0]       HI     = BOUNDS[ADDR_W-1:0];
        assign hit[k] = active && (cpu_addr >= LO) && (cpu_addr <= HI);
    end

    assign wram_cs_n   = !hit[0];
    assign pal_cs_n    = !hit[1];
    assign fixrom_cs_n = !hit[2];

    AST_FIXED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> (wram_cs_n && pal_cs_n && fixrom_cs_n)); // R10
    AST_FIXED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hc800 && cpu_addr < 16'he000) |-> (wram_cs_n && pal_cs_n && fixrom_cs_n)); // R9

endmodule

// File: rtl/paged_rom_decoder.sv
module paged_rom_decoder
    import prw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hc900,
    parameter logic [ADDR_W-1:0] WIN_LAST  = 16'h9fff
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    output logic [NUM_ROM-1:0] rom_cs_n,
    output logic               wram_cs_n,
    output logic               pal_cs_n,
    output logic               fixrom_cs_n,
    output logic [IMG_W-1:0]   bank_addr,
    output logic               fill_oe
);

    logic [PAGE_W-1:0] page;
    logic              unused_data_hi;

    assign unused_data_hi = ^cpu_wdata[7:PAGE_W];

    prw_page_reg #(
        .AW        (ADDR_W),
        .PW        (PAGE_W),
        .PAGE_ADDR (PAGE_ADDR)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .wdata_lo (cpu_wdata[PAGE_W-1:0]),
        .cpu_wr   (cpu_wr),
        .page     (page)
    );

    prw_window_decode #(
        .AW       (ADDR_W),
        .PW       (PAGE_W),
        .NROM     (NUM_ROM),
        .BAW      (IMG_W),
        .WIN_LAST (WIN_LAST)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .page      (page),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .rom_cs_n  (rom_cs_n),
        .bank_addr (bank_addr),
        .fill_oe   (fill_oe)
    );

    prw_fixed_decode #(
        .AW (ADDR_W)
    ) u_fixed (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .wram_cs_n   (wram_cs_n),
        .pal_cs_n    (pal_cs_n),
        .fixrom_cs_n (fixrom_cs_n)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rom_cs_n, ~wram_cs_n, ~pal_cs_n, ~fixrom_cs_n}) <= 1); // R10

endmodule

// File: tb/paged_rom_decoder_bench.sv
`timescale 1ns/1ps
module paged_rom_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [4:0]  rom_cs_n;
    logic        wram_cs_n, pal_cs_n, fixrom_cs_n;
    logic [16:0] bank_addr;
    logic        fill_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    paged_rom_decoder u_paged_rom_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_cs_n(rom_cs_n),
        .wram_cs_n(wram_cs_n), .pal_cs_n(pal_cs_n), .fixrom_cs_n(fixrom_cs_n),
        .bank_addr(bank_addr), .fill_oe(fill_oe)
    );

    // {req[3:0], page[3:0], addr[15:0], rd, wr, rom_cs_n[4:0], ram,pal,fix (n), bank[16:0], fill}
    localparam int NV = 26;
    localparam logic [51:0] VEC [NV] = '{
        {4'd2, 4'h0, 16'h0000, 2'b10, 5'b11110, 3'b111, 17'h00000, 1'b0}, // R2 R1 device first byte
        {4'd2, 4'h0, 16'h3fff, 2'b10, 5'b11110, 3'b111, 17'h03fff, 1'b0}, // R2
        {4'd2, 4'h0, 16'h4000, 2'b10, 5'b11011, 3'b111, 17'h08000, 1'b0}, // R2 R3 device
        {4'd5, 4'h0, 16'h7abc, 2'b10, 5'b11011, 3'b111, 17'h0babc, 1'b0}, // R5 offset
        {4'd2, 4'h0, 16'h8000, 2'b10, 5'b01111, 3'b111, 17'h10000, 1'b0}, // R2 R5 device
        {4'd5, 4'h0, 16'h9fff, 2'b10, 5'b01111, 3'b111, 17'h11fff, 1'b0}, // R5 last byte
        {4'd3, 4'h4, 16'h0123, 2'b10, 5'b11101, 3'b111, 17'h04123, 1'b0}, // R3 R2 device
        {4'd3, 4'h4, 16'h5000, 2'b10, 5'b10111, 3'b111, 17'h0d000, 1'b0}, // R3 R4 device
        {4'd3, 4'h4, 16'h8000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b1}, // R3 hole, R8 fill
        {4'd4, 4'h8, 16'h1234, 2'b10, 5'b11110, 3'b111, 17'h01234, 1'b0}, // R4 alias of 0
        {4'd4, 4'hc, 16'h4567, 2'b10, 5'b10111, 3'b111, 17'h0c567, 1'b0}, // R4 alias of 4
        {4'd4, 4'hc, 16'h9000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b1}, // R4 hole
        {4'd6, 4'h0, 16'h1000, 2'b01, 5'b11111, 3'b111, 17'h00000, 1'b0}, // R6 write in window
        {4'd7, 4'h1, 16'h1000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b1}, // R7
        {4'd7, 4'h6, 16'h4000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b1}, // R7
        {4'd7, 4'h3, 16'h8000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b1}, // R7
        {4'd9, 4'h4, 16'ha000, 2'b10, 5'b11111, 3'b011, 17'h00000, 1'b0}, // R9 work RAM
        {4'd9, 4'h1, 16'hbfff, 2'b01, 5'b11111, 3'b011, 17'h00000, 1'b0}, // R9
        {4'd9, 4'h0, 16'hc000, 2'b10, 5'b11111, 3'b101, 17'h00000, 1'b0}, // R9 palette
        {4'd9, 4'h0, 16'hc7ff, 2'b01, 5'b11111, 3'b101, 17'h00000, 1'b0}, // R9
        {4'd9, 4'h0, 16'hc800, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b0}, // R9 gap
        {4'd9, 4'h0, 16'hd000, 2'b10, 5'b11111, 3'b111, 17'h00000, 1'b0}, // R9 gap
        {4'd9, 4'hf, 16'he000, 2'b10, 5'b11111, 3'b110, 17'h00000, 1'b0}, // R9 fixed ROM
        {4'd9, 4'h0, 16'hffff, 2'b10, 5'b11111, 3'b110, 17'h00000, 1'b0}, // R9
        {4'd9, 4'h2, 16'hffff, 2'b01, 5'b11111, 3'b110, 17'h00000, 1'b0}, // R9 write
        {4'd10,4'h0, 16'h2000, 2'b00, 5'b11111, 3'b111, 17'h00000, 1'b0}  // R10 idle
    };

    task automatic check(input int req, input logic [25:0] act, input logic [25:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual cs/bank/fill=%h expected=%h (addr %h)",
                     req, act, exp, cpu_addr);
        end
    endtask

    function automatic logic [25:0] outs();
        return {rom_cs_n, wram_cs_n, pal_cs_n, fixrom_cs_n, bank_addr, fill_oe};
    endfunction

    task automatic write_page(input logic [3:0] p, input logic [3:0] junk);
        @(negedge clk);
        cpu_addr = 16'hc900; cpu_wdata = {junk, p}; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic drive_and_check(input int req, input logic [15:0] a, input logic rd,
                                   input logic wr, input logic [25:0] exp);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        check(req, outs(), exp);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    initial begin
        #(5 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: all selects idle.
        check(10, outs(), {5'b11111, 3'b111, 17'h0, 1'b0}); // R10
        rst_n = 1'b1;
        // R1: page is 0 after reset, so a read at 0x0000 picks R1 device.
        drive_and_check(1, 16'h0005, 1'b1, 1'b0, {5'b11110, 3'b111, 17'h00005, 1'b0});

        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            v = VEC[i];
            write_page(v[47:44], 4'(i));
            drive_and_check(int'(v[51:48]), v[43:28], v[27], v[26], v[25:0]);
        end

        // R1: upper data bits ignored; load page 4 with junk 0xF in bits 7:4.
        write_page(4'h4, 4'hf);
        drive_and_check(1, 16'h0010, 1'b1, 1'b0, {5'b11101, 3'b111, 17'h04010, 1'b0});
        // R1: write to another address does not load the page.
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_wdata = 8'h00; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        drive_and_check(1, 16'h0010, 1'b1, 1'b0, {5'b11101, 3'b111, 17'h04010, 1'b0});
        // R1: a read at the page address does not load it.
        @(negedge clk);
        cpu_addr = 16'hc900; cpu_wdata = 8'h00; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        drive_and_check(1, 16'h4000, 1'b1, 1'b0, {5'b10111, 3'b111, 17'h0c000, 1'b0});
        // R10: page write cycle itself asserts no select.
        @(negedge clk);
        cpu_addr = 16'hc900; cpu_wdata = 8'h00; cpu_wr = 1'b1;
        #1;
        check(10, outs(), {5'b11111, 3'b111, 17'h0, 1'b0});
        @(negedge clk);
        cpu_wr = 1'b0;
        // R2 after page returns to 0.
        drive_and_check(2, 16'h9abc, 1'b1, 1'b0, {5'b01111, 3'b111, 17'h11abc, 1'b0});
        // R1: reset returns page to 0.
        write_page(4'h4, 4'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive_and_check(1, 16'h0000, 1'b1, 1'b0, {5'b11110, 3'b111, 17'h00000, 1'b0});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule